// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block turns single-byte read requests from a simple memory-mapped bus into complete SPI flash read transactions. For each accepted request it lowers chip select and sends the read opcode. It then sends the address, spends the programmed number of dummy periods and shifts in one data byte. It raises chip select, returns the byte with a one-cycle response pulse, and holds chip select high for a programmed idle width before it takes the next request.

Two configuration words shape each transaction. The control word sets the line mode (single, dual data only, or dual address-and-data), the opcode, the 3- or 4-byte address width, the fast-read dummy bytes, the SPI clock divider and the idle width. The timing word holds one input-sample delay code for each of the five fastest dividers. The active code compensates for the round-trip delay through the pads at that clock rate. Both words are captured when a request is accepted, so software may rewrite them while a transaction is in flight.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset spi_cs_n is 1, and busy, rsp_valid, spi_sclk and both spi_io_oe bits are 0.
- R2: Every transaction starts with the opcode (control bits 23:16), MSB first, one bit per SPI period on spi_io_o[0], with spi_io_oe = 2'b01.
- R3: The address follows MSB first. It is 4 bytes when control bit 13 is 1, otherwise 3 bytes (req_addr[23:0]). In mode 3 (bits 29:28 = 3) it moves two bits per period, the higher bit on spi_io_o[1], with spi_io_oe = 2'b11. Otherwise it moves one bit per period on spi_io_o[0] with spi_io_oe = 2'b01.
- R4: When control bit 0 is 1, bits 7:6 give a number of dummy bytes, each lasting 4 periods in mode 3 and 8 periods otherwise. During dummy and data periods spi_io_oe is 2'b00.
- R5: In modes 2 and 3 the data byte takes 4 periods, two bits per period with the higher bit on spi_io_i[1]. In modes 0 and 1 it takes 8 periods on spi_io_i[1]. Bits arrive MSB first. rsp_valid is high for exactly one cycle, carrying the byte in rsp_data, in the first cycle in which spi_cs_n is high again.
- R6: The SPI period is N bus clocks, where divider code (bits 11:8) 0xF, 0x7, 0xE, 0x6, 0xD and 0x0 give N = 1, 2, 3, 4, 5 and 16. Within each period spi_sclk is low for the first floor(N/2) cycles and high for the rest. spi_sclk is low while spi_cs_n is high.
- R7: For divider N from 1 to 5, the timing field at bits (N-1)*4+3:(N-1)*4 is used. Its bits 2:0 plus its bit 3 give a delay d. The bit of each period is the spi_io_i value at the clock edge d+1 edges before the edge that ends the period. For N above 5, d is 0.
- R8: Idle code (bits 27:24) 0xE, 0xD, 0xC, 0xA, 0x6 and 0x0 give W = 2, 3, 4, 6, 10 and 16 periods. busy rises together with the falling edge of spi_cs_n and stays high until exactly W*N bus clocks after spi_cs_n rises.
- R9: A request (req_valid high at a clock edge) is accepted only when busy is low. A request made while busy is high is ignored.
- R10: Changes to cfg_ctrl and cfg_timing after a request is accepted do not affect that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 32 | Read control word |
| cfg_timing | input | 32 | Per-divider input-sample delay codes |
| req_valid | input | 1 | Read request |
| req_addr | input | 32 | Byte address of the read |
| busy | output | 1 | Transaction or idle gap in progress |
| rsp_valid | output | 1 | One-cycle pulse carrying the read byte |
| rsp_data | output | 8 | Read byte |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_o | output | 2 | Output values for IO1/IO0 |
| spi_io_oe | output | 2 | Output enables for IO1/IO0 |
| spi_io_i | input | 2 | Input values from IO1/IO0 |

## Verification
Two events can land on one clock edge: the capture of the last data period, with the raising of chip select and the response, and the arrival of a new request on the first edge at which busy is clear. The bench issues each request at the falling clock edge at which it first sees busy low. Back-to-back requests therefore arrive on the very first idle edge. For every transaction the bench predicts, by cycle count, the edge at which chip select must fall and the edge at which busy must clear. It drives spi_io_i with random values everywhere except the one edge that each data period actually samples. An engine that reads a neighbouring edge therefore returns a wrong byte.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int CTRL_W     = 32;
    localparam int OPC_W      = 8;
    localparam int ADDR_W     = 32;
    localparam int TX_W       = OPC_W + ADDR_W;
    localparam int NUM_TAPS   = 5;
    localparam int TAP_FLD_W  = 4;
    localparam int TIMING_W   = NUM_TAPS * TAP_FLD_W;
    localparam int HIST_DEPTH = 9;
    localparam int DIV_W      = 5;
    localparam int BEAT_W     = 6;
    localparam int GAP_W      = 9;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_GAP
    } phase_e;

    typedef struct packed {
        phase_e              st;
        logic [DIV_W-1:0]    div;
        logic [BEAT_W-1:0]   beat;
        logic [TX_W-1:0]     tx;
        logic [7:0]          rx;
        logic [GAP_W-1:0]    gap;
        logic [CTRL_W-1:0]   ctrl;
        logic [TIMING_W-1:0] timing;
        logic                rsp_valid;
        logic [7:0]          rsp_data;
    } eng_t;
endpackage

// File: rtl/sfr_cfg_decode.sv
module sfr_cfg_decode
    import sfr_pkg::*;
(
    input  logic [CTRL_W-1:0]   ctrl,
    input  logic [TIMING_W-1:0] timing,
    output logic [DIV_W-1:0]    div_n,
    output logic [GAP_W-1:0]    gap_cyc,
    output logic                dual_addr,
    output logic                dual_data,
    output logic [BEAT_W-1:0]   addr_beats,
    output logic [BEAT_W-1:0]   dummy_beats,
    output logic [BEAT_W-1:0]   data_beats,
    output logic [3:0]          tap_idx
);
    logic [4:0]           gap_w;
    logic [TAP_FLD_W-1:0] fld;

    always_comb begin
        div_n     = 5'd16 - {1'b0, ctrl[10:8], 1'b0} - {4'd0, ctrl[11]};
        gap_w     = 5'd16 - {1'b0, ctrl[27:24]};
        gap_cyc   = GAP_W'({5'd0, gap_w} * {5'd0, div_n});
        dual_addr = (ctrl[29:28] == 2'b11);
        dual_data = ctrl[29];
        case ({ctrl[13], dual_addr})
            2'b00:   addr_beats = 6'd24;
            2'b01:   addr_beats = 6'd12;
            2'b10:   addr_beats = 6'd32;
            default: addr_beats = 6'd16;
        endcase
        if (!ctrl[0])
            dummy_beats = '0;
        else if (dual_addr)
            dummy_beats = {2'b0, ctrl[7:6], 2'b0};
        else
            dummy_beats = {1'b0, ctrl[7:6], 3'b0};
        data_beats = dual_data ? 6'd4 : 6'd8;
        fld = '0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (div_n == DIV_W'(i + 1))
                fld = timing[i*TAP_FLD_W +: TAP_FLD_W];
        end
        tap_idx = {1'b0, fld[2:0]} + {3'b0, fld[3]};
    end
endmodule

// File: rtl/sfr_sample_tap.sv
module sfr_sample_tap #(
    parameter int DEPTH = 9,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       io_i,
    input  logic [SEL_W-1:0] sel,
    output logic [1:0]       smp
);
    logic [DEPTH-1:0][1:0] hist_d, hist_q;

    always_comb begin
        hist_d[0] = io_i;
        for (int i = 1; i < DEPTH; i++)
            hist_d[i] = hist_q[i-1];
        smp = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i))
                smp = hist_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [31:0]       cfg_timing,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic [1:0]        spi_io_o,
    output logic [1:0]        spi_io_oe,
    input  logic [1:0]        spi_io_i
);
    eng_t s_d, s_q;

    logic [DIV_W-1:0]  div_n;
    logic [GAP_W-1:0]  gap_cyc;
    logic              dual_addr, dual_data;
    logic [BEAT_W-1:0] addr_beats, dummy_beats, data_beats;
    logic [3:0]        tap_idx;
    logic [1:0]        smp;
    logic              active, period_end;
    logic [7:0]        rx_next;

    sfr_cfg_decode u_dec (
        .ctrl        (s_q.ctrl),
        .timing      (s_q.timing),
        .div_n       (div_n),
        .gap_cyc     (gap_cyc),
        .dual_addr   (dual_addr),
        .dual_data   (dual_data),
        .addr_beats  (addr_beats),
        .dummy_beats (dummy_beats),
        .data_beats  (data_beats),
        .tap_idx     (tap_idx)
    );

    sfr_sample_tap #(.DEPTH(HIST_DEPTH), .SEL_W(4)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .io_i  (spi_io_i),
        .sel   (tap_idx),
        .smp   (smp)
    );

    always_comb begin
        active     = (s_q.st != PH_IDLE) && (s_q.st != PH_GAP);
        period_end = active && (s_q.div == div_n - 5'd1);
        rx_next    = dual_data ? {s_q.rx[5:0], smp} : {s_q.rx[6:0], smp[1]};

        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        case (s_q.st)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.st     = PH_CMD;
                    s_d.div    = '0;
                    s_d.beat   = BEAT_W'(OPC_W);
                    s_d.rx     = '0;
                    s_d.ctrl   = cfg_ctrl;
                    s_d.timing = cfg_timing[TIMING_W-1:0];
                    s_d.tx     = cfg_ctrl[13] ? {cfg_ctrl[23:16], req_addr}
                                              : {cfg_ctrl[23:16], req_addr[23:0], 8'h00};
                end
            end
            PH_GAP: begin
                if (s_q.gap == gap_cyc - 9'd1) s_d.st  = PH_IDLE;
                else                           s_d.gap = s_q.gap + 9'd1;
            end
            default: begin
                if (!period_end) begin
                    s_d.div = s_q.div + 5'd1;
                end else begin
                    s_d.div  = '0;
                    s_d.beat = s_q.beat - 6'd1;
                    if (s_q.st == PH_CMD || (s_q.st == PH_ADDR && !dual_addr))
                        s_d.tx = {s_q.tx[TX_W-2:0], 1'b0};
                    else if (s_q.st == PH_ADDR)
                        s_d.tx = {s_q.tx[TX_W-3:0], 2'b00};
                    if (s_q.st == PH_DATA)
                        s_d.rx = rx_next;
                    if (s_q.beat == 6'd1) begin
                        case (s_q.st)
                            PH_CMD: begin
                                s_d.st   = PH_ADDR;
                                s_d.beat = addr_beats;
                            end
                            PH_ADDR: begin
                                if (dummy_beats != '0) begin
                                    s_d.st   = PH_DUMMY;
                                    s_d.beat = dummy_beats;
                                end else begin
                                    s_d.st   = PH_DATA;
                                    s_d.beat = data_beats;
                                end
                            end
                            PH_DUMMY: begin
                                s_d.st   = PH_DATA;
                                s_d.beat = data_beats;
                            end
                            default: begin
                                s_d.st        = PH_GAP;
                                s_d.gap       = '0;
                                s_d.rsp_valid = 1'b1;
                                s_d.rsp_data  = rx_next;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy      = (s_q.st != PH_IDLE);
        spi_cs_n  = !active;
        spi_sclk  = active && (s_q.div >= (div_n >> 1));
        rsp_valid = s_q.rsp_valid;
        rsp_data  = s_q.rsp_data;
        spi_io_o  = 2'b00;
        spi_io_oe = 2'b00;
        if (s_q.st == PH_CMD) begin
            spi_io_o  = {1'b0, s_q.tx[TX_W-1]};
            spi_io_oe = 2'b01;
        end else if (s_q.st == PH_ADDR) begin
            spi_io_o  = dual_addr ? s_q.tx[TX_W-1:TX_W-2] : {1'b0, s_q.tx[TX_W-1]};
            spi_io_oe = dual_addr ? 2'b11 : 2'b01;
        end
    end
endmodule

// File: rtl/sfr_read_engine_chk.sv
module sfr_read_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rsp_valid,
    input logic       spi_sclk,
    input logic       spi_cs_n,
    input logic [1:0] spi_io_oe
);
    AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);                                  // R8
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                            // R5
    AST_RSP_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(spi_cs_n));                       // R5
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);                              // R6
    AST_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_io_oe == 2'b00));                   // R1
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !$past(busy));                    // R9
endmodule

bind sfr_read_engine sfr_read_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_io_oe (spi_io_oe)
);

// File: tb/sim_sfr_read_engine.sv
module sim_sfr_read_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ctrl = '0, cfg_timing = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, rsp_valid, spi_sclk, spi_cs_n;
    logic [7:0]  rsp_data;
    logic [1:0]  spi_io_o, spi_io_oe;
    logic [1:0]  spi_io_i = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    sfr_read_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
        .spi_io_i(spi_io_i)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: act=%0d exp<190000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int f_div(input logic [3:0] c);
        case (c)
            4'hF: return 1;  4'h7: return 2;  4'hE: return 3;
            4'h6: return 4;  4'hD: return 5;  default: return 16;
        endcase
    endfunction

    function automatic int f_gap(input logic [3:0] c);
        case (c)
            4'hE: return 2;  4'hD: return 3;  4'hC: return 4;
            4'hA: return 6;  4'h6: return 10; default: return 16;
        endcase
    endfunction

    function automatic int f_tap(input int n, input logic [31:0] t);
        logic [3:0] f;
        if (n > 5) return 0;
        f = t[(n-1)*4 +: 4];
        return int'(f[2:0]) + int'(f[3]);
    endfunction

    // Caller must be at a falling clock edge.
    task automatic run_txn(input logic [1:0] mode, input logic [3:0] divc, input logic [3:0] gapc,
                           input logic [7:0] op, input logic [31:0] addr, input bit a4,
                           input bit fast, input logic [1:0] dmy, input logic [31:0] tim,
                           input logic [7:0] dbyte, input bit poke);
        int n, g, idx, ab, db, nd, dstart, btot, last;
        bit dual_a, dual_d;
        bit e_cs, e_sclk, e_oe, e_quiet;
        logic [7:0]  op_got;
        logic [31:0] ad_got, ad_exp;
        logic [31:0] ctl;
        n = f_div(divc); g = f_gap(gapc) * n; idx = f_tap(n, tim);
        dual_a = (mode == 2'd3); dual_d = mode[1];
        ab = (a4 ? 4 : 3) * (dual_a ? 4 : 8);
        db = fast ? int'(dmy) * (dual_a ? 4 : 8) : 0;
        nd = dual_d ? 4 : 8;
        dstart = 8 + ab + db; btot = dstart + nd;
        last = btot * n + g;
        ctl = {2'b00, mode, gapc, op, 2'b00, a4, 1'b0, divc, dmy, 5'b0, fast};
        e_cs = 0; e_sclk = 0; e_oe = 0; e_quiet = 0;
        op_got = '0; ad_got = '0;
        ad_exp = a4 ? addr : {8'h00, addr[23:0]};

        while (busy) @(negedge clk);
        cfg_ctrl = ctl; cfg_timing = tim; req_addr = addr; req_valid = 1'b1;
        spi_io_i = 2'($urandom);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_ctrl = $urandom;   // R10: scrambled after acceptance
        cfg_timing = $urandom;
        req_addr = $urandom;
        for (int k = 0; k <= last; k++) begin
            int b, kk, b2, j;
            if (k < btot * n) begin
                b = k / n;
                if (spi_cs_n !== 1'b0) e_cs = 1;
                if (spi_sclk !== ((k % n) >= (n / 2))) e_sclk = 1;
                if (rsp_valid !== 1'b0) e_quiet = 1;
                if (k % n == 0) begin
                    if (b < 8) begin
                        op_got = {op_got[6:0], spi_io_o[0]};
                        if (spi_io_oe !== 2'b01) e_oe = 1;
                    end else if (b < 8 + ab) begin
                        if (dual_a) ad_got = {ad_got[29:0], spi_io_o};
                        else        ad_got = {ad_got[30:0], spi_io_o[0]};
                        if (spi_io_oe !== (dual_a ? 2'b11 : 2'b01)) e_oe = 1;
                    end else if (spi_io_oe !== 2'b00) e_oe = 1;
                end
            end
            if (k == btot * n) begin
                chk(!e_cs, "R2 cs_low_through_txn", e_cs, 0);
                chk(!e_sclk, "R6 sclk_shape", e_sclk, 0);
                chk(!e_oe, "R4 output_enables", e_oe, 0);
                chk(!e_quiet, "R5 no_early_rsp", e_quiet, 0);
                chk(op_got == op, "R2 opcode", op_got, op);
                chk(ad_got == ad_exp, "R3 address", ad_got, ad_exp);
                chk(spi_cs_n === 1'b1, "R5 cs_rise", spi_cs_n, 1);
                chk(rsp_valid === 1'b1, "R5 rsp_valid", rsp_valid, 1);
                chk(rsp_data === dbyte, "R7 rsp_data", rsp_data, dbyte);
            end
            if (k == btot * n + 1)
                chk(rsp_valid === 1'b0, "R5 rsp_single", rsp_valid, 0);
            if (k == last - 1) chk(busy === 1'b1, "R8 busy_during_gap", busy, 1);
            if (k == last)     chk(busy === 1'b0, "R8 busy_clears", busy, 0);
            if (poke) req_valid = (k == 3);   // R9: request while busy
            kk = k + 1;
            b2 = (kk + idx) / n;
            if (b2 >= dstart && b2 < btot) begin
                j = b2 - dstart;
                if (dual_d) spi_io_i = 2'((dbyte >> (6 - 2*j)) & 8'h3);
                else        spi_io_i = {dbyte[7-j], 1'($urandom)};
            end else spi_io_i = 2'($urandom);
            if (k != last) @(negedge clk);
        end
        if (poke) begin
            for (int m = 0; m < 3; m++) begin
                @(negedge clk);
                chk(spi_cs_n === 1'b1 && busy === 1'b0, "R9 busy_request_ignored",
                    {spi_cs_n, busy}, 2'b10);
            end
        end
    endtask

    initial begin
        logic [3:0] divs [6] = '{4'hF, 4'h7, 4'hE, 4'h6, 4'hD, 4'h0};
        logic [3:0] gaps [6] = '{4'hE, 4'hD, 4'hC, 4'hA, 4'h6, 4'h0};
        logic [1:0] modes [3] = '{2'd0, 2'd2, 2'd3};
        void'($urandom(32'd20141015));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n === 1'b1 && busy === 1'b0 && rsp_valid === 1'b0 &&
            spi_sclk === 1'b0 && spi_io_oe === 2'b00, "R1 reset_state",
            {spi_cs_n, busy, rsp_valid, spi_sclk, spi_io_oe}, 6'b100000);
        // directed corners
        run_txn(2'd0, 4'hF, 4'hE, 8'h03, 32'h00A5C3E1, 0, 0, 2'd0, 32'h0, 8'hB6, 0);
        run_txn(2'd3, 4'h0, 4'h0, 8'hBB, 32'hDEADBEEF, 1, 1, 2'd2, 32'hFFFFF, 8'h5A, 0);
        run_txn(2'd2, 4'hE, 4'hD, 8'h3B, 32'h00123456, 0, 1, 2'd1, 32'h00000B00, 8'hC9, 0);
        run_txn(2'd3, 4'h7, 4'hC, 8'hBB, 32'h89ABCDEF, 1, 1, 2'd1, 32'h00000030, 8'h17, 1);
        run_txn(2'd0, 4'hD, 4'h6, 8'h0B, 32'h00FEDCBA, 0, 1, 2'd3, 32'h000F0000, 8'hE4, 0);
        run_txn(2'd3, 4'hF, 4'hE, 8'hBB, 32'h01020304, 1, 1, 2'd3, 32'h0000000F, 8'h81, 0);
        // constrained random
        for (int t = 0; t < 30; t++) begin
            run_txn(modes[$urandom % 3], divs[$urandom % 6], gaps[$urandom % 6],
                    8'($urandom), $urandom, 1'($urandom), 1'($urandom), 2'($urandom),
                    $urandom, 8'($urandom), ($urandom % 4) == 0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule